// File: doc/BRIEF.md
# Flash Write-Completion Poller

This block sits on the host side of a byte-wide parallel flash bus. Once a program or erase has been launched, a one-cycle start pulse hands it the target address, the byte the location should hold when the operation is finished, and a detection mode. For an erase that byte is FFH. The block then runs read cycles on the bus until it decides that the device has finished. It ends with a single-cycle done pulse and a fail flag.

Two detection methods are offered. In mode 0 the block compares bit 7 of each status read with bit 7 of the expected byte. In mode 1 it checks whether bit 6 stops changing between consecutive reads. The internal operation ends at a time unrelated to the host's reads, so one status read can straddle the moment of completion. A status read that looks complete is therefore only a candidate. Two more reads of the target must both return the full expected byte before success is declared. A limit on the number of reads turns a device that never finishes into a failed result.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, the chip-enable, output-enable and write-enable outputs are high, and done_o, busy_o and fail_o are low.
- R2: start_i is accepted only while busy_o is low. The address captured at acceptance is driven on flash_addr_o for the whole operation. A start pulse while busy_o is high changes neither the address, the reads nor the result.
- R3: Each read cycle drives chip-enable and output-enable low together for exactly RD_CLKS clocks, and the data bus is sampled on the last of those clocks. At least one clock with both high separates two reads, and write-enable stays high at all times.
- R4: In mode 0 (data polling), a status read is a candidate completion when its bit 7 equals bit 7 of the expected byte.
- R5: In mode 1 (toggle), the first status read only sets a reference. A later status read is a candidate when its bit 6 equals bit 6 of the read just before it.
- R6: After a candidate, two confirming reads follow. The operation passes (done_o with fail_o low) only when both return the whole expected byte.
- R7: A confirming read that differs from the expected byte ends the confirmation at once, and the second read is skipped. Status polling then resumes. In mode 1 the next status read becomes a fresh reference.
- R8: Every read counts toward MAX_POLLS. If the MAX_POLLS-th read does not complete a pass, the operation ends with fail_o high, and exactly MAX_POLLS reads have been made.
- R9: done_o is a one-cycle pulse, and busy_o is low from that cycle on. fail_o holds the result until the next accepted start. No read cycle is issued while busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin polling |
| addr_i | input | AW | Location written by the launched operation |
| expect_i | input | 8 | Byte expected at completion (FFH for erase) |
| mode_i | input | 1 | 0 = bit-7 data polling, 1 = bit-6 toggle detection |
| flash_addr_o | output | AW | Flash address bus |
| flash_ce_n_o | output | 1 | Flash chip enable, active low |
| flash_oe_n_o | output | 1 | Flash output enable, active low |
| flash_we_n_o | output | 1 | Flash write enable, active low, held high |
| flash_dq_i | input | 8 | Flash data bus |
| busy_o | output | 1 | An operation is being polled |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Result: high when the read limit was reached without confirmation |

## Verification
The assertions assume that the flash data bus is stable while the output-enable strobe is low. They also assume that start_i is a single-cycle pulse with the address, expected byte and mode valid alongside it. The bench's flash model changes its data only after a read's strobe has risen. The bench drives start_i and its companions on falling clock edges for one cycle. Each scenario loads a per-read response list, so busy, candidate, spurious and never-finishing devices are all modelled by the bytes the model returns, read by read.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

    localparam int BYTE_W     = 8;
    localparam int BIT_DPOLL  = 7;
    localparam int BIT_TOGGLE = 6;

    typedef enum logic {
        MODE_DATA   = 1'b0,
        MODE_TOGGLE = 1'b1
    } poll_mode_e;

    typedef enum logic [1:0] {
        PH_STATUS = 2'd0,
        PH_CONF_A = 2'd1,
        PH_CONF_B = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        BUS_IDLE   = 2'd0,
        BUS_ACTIVE = 2'd1,
        BUS_GAP    = 2'd2
    } bus_st_e;

    typedef struct packed {
        logic [BYTE_W-1:0] expect_b;
        poll_mode_e        mode;
    } poll_ctx_t;

    // Decide whether one status read suggests the operation has finished.
    function automatic logic status_hit(poll_ctx_t ctx, logic [BYTE_W-1:0] rd,
                                        logic [BYTE_W-1:0] prev, logic have_ref);
        if (ctx.mode == MODE_DATA)
            return rd[BIT_DPOLL] == ctx.expect_b[BIT_DPOLL];
        else
            return have_ref && (rd[BIT_TOGGLE] == prev[BIT_TOGGLE]);
    endfunction

endpackage

// File: rtl/fpoll_bus.sv
module fpoll_bus
    import fpoll_pkg::*;
#(
    parameter int RD_CLKS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [BYTE_W-1:0] dq_i,
    output logic              strobe_n_o,
    output logic              ack_o,
    output logic [BYTE_W-1:0] data_o
);

    localparam int CNT_W = $clog2(RD_CLKS + 1);

    bus_st_e          st;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= BUS_IDLE;
            cnt    <= '0;
            ack_o  <= 1'b0;
            data_o <= '0;
        end else begin
            ack_o <= 1'b0;
            case (st)
                BUS_IDLE: begin
                    if (req_i) begin
                        st  <= BUS_ACTIVE;
                        cnt <= '0;
                    end
                end
                BUS_ACTIVE: begin
                    if (cnt == CNT_W'(RD_CLKS - 1)) begin
                        st     <= BUS_GAP;
                        ack_o  <= 1'b1;
                        data_o <= dq_i;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                BUS_GAP: st <= BUS_IDLE;
                default: st <= BUS_IDLE;
            endcase
        end
    end

    assign strobe_n_o = (st != BUS_ACTIVE);

endmodule

// File: rtl/fpoll_seq.sv
module fpoll_seq
    import fpoll_pkg::*;
#(
    parameter int AW        = 17,
    parameter int MAX_POLLS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [BYTE_W-1:0] expect_i,
    input  logic              mode_i,
    output logic              rd_req_o,
    input  logic              rd_ack_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [AW-1:0]     addr_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o
);

    localparam int NR_W = $clog2(MAX_POLLS + 1);

    poll_ctx_t         ctx;
    phase_e            phase;
    logic              have_ref;
    logic [BYTE_W-1:0] prev;
    logic [NR_W-1:0]   nreads;
    logic [NR_W-1:0]   nreads_n;
    logic              hit;
    logic              byte_ok;

    always_comb begin
        nreads_n = nreads + NR_W'(1);
        hit      = status_hit(ctx, rd_data_i, prev, have_ref);
        byte_ok  = (rd_data_i == ctx.expect_b);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx      <= '0;
            addr_o   <= '0;
            phase    <= PH_STATUS;
            have_ref <= 1'b0;
            prev     <= '0;
            nreads   <= '0;
            busy_o   <= 1'b0;
            done_o   <= 1'b0;
            fail_o   <= 1'b0;
            rd_req_o <= 1'b0;
        end else begin
            done_o   <= 1'b0;
            rd_req_o <= 1'b0;
            if (!busy_o) begin
                if (start_i) begin
                    ctx.expect_b <= expect_i;
                    ctx.mode     <= poll_mode_e'(mode_i);
                    addr_o       <= addr_i;
                    phase        <= PH_STATUS;
                    have_ref     <= 1'b0;
                    nreads       <= '0;
                    busy_o       <= 1'b1;
                    fail_o       <= 1'b0;
                    rd_req_o     <= 1'b1;
                end
            end else if (rd_ack_i) begin
                nreads <= nreads_n;
                prev   <= rd_data_i;
                if (phase == PH_CONF_B && byte_ok) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                    fail_o <= 1'b0;
                end else if (nreads_n == NR_W'(MAX_POLLS)) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                    fail_o <= 1'b1;
                end else begin
                    rd_req_o <= 1'b1;
                    case (phase)
                        PH_STATUS: begin
                            if (hit) phase <= PH_CONF_A;
                            else     have_ref <= 1'b1;
                        end
                        PH_CONF_A: begin
                            if (byte_ok) begin
                                phase <= PH_CONF_B;
                            end else begin
                                phase    <= PH_STATUS;
                                have_ref <= 1'b0;
                            end
                        end
                        default: begin
                            phase    <= PH_STATUS;
                            have_ref <= 1'b0;
                        end
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
    import fpoll_pkg::*;
#(
    parameter int AW        = 17,
    parameter int RD_CLKS   = 3,
    parameter int MAX_POLLS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [BYTE_W-1:0] expect_i,
    input  logic              mode_i,
    output logic [AW-1:0]     flash_addr_o,
    output logic              flash_ce_n_o,
    output logic              flash_oe_n_o,
    output logic              flash_we_n_o,
    input  logic [BYTE_W-1:0] flash_dq_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o
);

    logic              rd_req;
    logic              rd_ack;
    logic [BYTE_W-1:0] rd_data;
    logic              strobe_n;

    fpoll_seq #(
        .AW        (AW),
        .MAX_POLLS (MAX_POLLS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .addr_i    (addr_i),
        .expect_i  (expect_i),
        .mode_i    (mode_i),
        .rd_req_o  (rd_req),
        .rd_ack_i  (rd_ack),
        .rd_data_i (rd_data),
        .addr_o    (flash_addr_o),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .fail_o    (fail_o)
    );

    fpoll_bus #(
        .RD_CLKS (RD_CLKS)
    ) u_bus (
        .clk        (clk),
        .rst        (rst),
        .req_i      (rd_req),
        .dq_i       (flash_dq_i),
        .strobe_n_o (strobe_n),
        .ack_o      (rd_ack),
        .data_o     (rd_data)
    );

    assign flash_ce_n_o = strobe_n;
    assign flash_oe_n_o = strobe_n;
    assign flash_we_n_o = 1'b1;

endmodule

// File: rtl/fpoll_chk.sv
module fpoll_chk #(
    parameter int AW      = 17,
    parameter int RD_CLKS = 3
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] flash_addr_o,
    input logic          flash_ce_n_o,
    input logic          flash_oe_n_o,
    input logic          flash_we_n_o,
    input logic          busy_o,
    input logic          done_o,
    input logic          fail_o
);

    localparam int LW = $clog2(RD_CLKS + 2);

    logic [LW-1:0] lowcnt;

    always_ff @(posedge clk) begin
        if (rst)                lowcnt <= '0;
        else if (!flash_oe_n_o) lowcnt <= lowcnt + LW'(1);
        else                    lowcnt <= '0;
    end

    assert_we_high_R3: assert property (@(posedge clk) disable iff (rst)
        flash_we_n_o);

    assert_strobes_paired_R3: assert property (@(posedge clk) disable iff (rst)
        flash_ce_n_o == flash_oe_n_o);

    assert_strobe_width_R3: assert property (@(posedge clk) disable iff (rst)
        (flash_oe_n_o && lowcnt != '0) |-> lowcnt == LW'(RD_CLKS));

    assert_strobe_gap_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(flash_oe_n_o) |=> flash_oe_n_o);

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(flash_addr_o));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> flash_oe_n_o);

    assert_fail_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(fail_o) |-> (done_o || $rose(busy_o)));

endmodule

bind flash_done_poller fpoll_chk #(
    .AW      (AW),
    .RD_CLKS (RD_CLKS)
) u_fpoll_chk (
    .clk          (clk),
    .rst          (rst),
    .flash_addr_o (flash_addr_o),
    .flash_ce_n_o (flash_ce_n_o),
    .flash_oe_n_o (flash_oe_n_o),
    .flash_we_n_o (flash_we_n_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .fail_o       (fail_o)
);

// File: tb/test_flash_done_poller.sv
`timescale 1ns/1ps
module test_flash_done_poller;

    localparam int AW        = 17;
    localparam int RD_CLKS   = 3;
    localparam int MAX_POLLS = 16;
    localparam int NRESP     = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [7:0]    expect_i = '0;
    logic          mode_i = 1'b0;
    logic [AW-1:0] flash_addr_o;
    logic          flash_ce_n_o, flash_oe_n_o, flash_we_n_o;
    logic [7:0]    flash_dq_i;
    logic          busy_o, done_o, fail_o;

    always #2 clk = ~clk;

    flash_done_poller #(
        .AW(AW), .RD_CLKS(RD_CLKS), .MAX_POLLS(MAX_POLLS)
    ) i_flash_done_poller (
        .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i),
        .expect_i(expect_i), .mode_i(mode_i), .flash_addr_o(flash_addr_o),
        .flash_ce_n_o(flash_ce_n_o), .flash_oe_n_o(flash_oe_n_o),
        .flash_we_n_o(flash_we_n_o), .flash_dq_i(flash_dq_i),
        .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
    );

    int total = 0;
    int fails = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Flash model: read k of the current case returns resp[k].
    logic [7:0] resp [NRESP];
    int rd_idx = 0;
    int base   = 0;
    always_comb begin
        int k;
        k = rd_idx - base;
        if (k < 0) k = 0;
        if (k > NRESP - 1) k = NRESP - 1;
        flash_dq_i = resp[k];
    end

    task automatic fill_tail(input int from);
        for (int j = from; j < NRESP; j++) resp[j] = resp[from - 1];
    endtask

    // Monitors, sampled on falling edges.
    logic          oe_q = 1'b1;
    int            lowcnt = 0;
    int            done_seen = 0;
    logic          done_q = 1'b0;
    logic [AW-1:0] cur_addr = '0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!oe_q && flash_oe_n_o) rd_idx++;
            if (!flash_oe_n_o) begin
                lowcnt++;
                if (flash_addr_o != cur_addr)
                    check(0, "R2", "address during read", int'(flash_addr_o), int'(cur_addr));
            end else if (lowcnt != 0) begin
                check(lowcnt == RD_CLKS, "R3", "strobe low width", lowcnt, RD_CLKS);
                lowcnt = 0;
            end
            if (flash_ce_n_o != flash_oe_n_o || !flash_we_n_o)
                check(0, "R3", "strobe pairing / write enable", int'(flash_we_n_o), 1);
            if (done_o && done_q)
                check(0, "R9", "done pulse width", 2, 1);
            if (done_o) done_seen++;
            oe_q   = flash_oe_n_o;
            done_q = done_o;
        end
    end

    task automatic run_case(input string req, input bit mode, input logic [7:0] expv,
                            input logic [AW-1:0] addr, input bit exp_fail,
                            input int exp_reads, input bit poke_start);
        int waited;
        int reads;
        base      = rd_idx;
        done_seen = 0;
        cur_addr  = addr;
        @(negedge clk);
        start_i  = 1'b1;
        mode_i   = mode;
        expect_i = expv;
        addr_i   = addr;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, req, "busy after start", int'(busy_o), 1);
        if (poke_start) begin
            repeat (5) @(negedge clk);
            start_i  = 1'b1;
            addr_i   = ~addr;
            mode_i   = ~mode;
            expect_i = ~expv;
            @(negedge clk);
            start_i = 1'b0;
        end
        waited = 0;
        while (done_seen == 0 && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        reads = rd_idx - base;
        check(done_seen == 1, req, "done pulse seen", done_seen, 1);
        check(fail_o == exp_fail, req, "fail flag", int'(fail_o), int'(exp_fail));
        check(reads == exp_reads, req, "read count", reads, exp_reads);
        check(busy_o == 1'b0, "R9", "busy low at done", int'(busy_o), 0);
        repeat (12) @(negedge clk);
        check(rd_idx - base == exp_reads, "R9", "no reads after done", rd_idx - base, exp_reads);
        check(done_seen == 1, "R9", "single done pulse", done_seen, 1);
        check(fail_o == exp_fail, "R9", "fail held", int'(fail_o), int'(exp_fail));
    endtask

    // R4/R6: immediate bit-7 match, two good confirms.
    task automatic t_dpoll_fast();
        resp[0] = 8'h5A; fill_tail(1);
        run_case("R4", 1'b0, 8'h5A, 17'h01234, 1'b0, 3, 1'b0);
    endtask

    // R4: three busy reads (bit 7 inverted) before completion.
    task automatic t_dpoll_busy();
        resp[0] = 8'hDA; resp[1] = 8'hDA; resp[2] = 8'hDA; resp[3] = 8'h5A; fill_tail(4);
        run_case("R4", 1'b0, 8'h5A, 17'h05555, 1'b0, 6, 1'b0);
    endtask

    // R7: first confirm mismatches, second confirm skipped, polling resumes.
    task automatic t_dpoll_spur_a();
        resp[0] = 8'h00; resp[1] = 8'hDA; resp[2] = 8'h5A; fill_tail(3);
        run_case("R7", 1'b0, 8'h5A, 17'h1FFFF, 1'b0, 5, 1'b0);
    endtask

    // R6: first confirm good, second bad -> no pass yet.
    task automatic t_dpoll_spur_b();
        resp[0] = 8'h5A; resp[1] = 8'h5A; resp[2] = 8'hDA; resp[3] = 8'h5A; fill_tail(4);
        run_case("R6", 1'b0, 8'h5A, 17'h00010, 1'b0, 6, 1'b0);
    endtask

    // R8: never completes in data-polling mode.
    task automatic t_dpoll_timeout();
        resp[0] = 8'hDA; fill_tail(1);
        run_case("R8", 1'b0, 8'h5A, 17'h0AAAA, 1'b1, MAX_POLLS, 1'b0);
    endtask

    // R5: toggling bit 6 until it settles, erase pattern FFH.
    task automatic t_toggle_basic();
        resp[0] = 8'h00; resp[1] = 8'h40; resp[2] = 8'h00; resp[3] = 8'hFF; fill_tail(4);
        run_case("R5", 1'b1, 8'hFF, 17'h00000, 1'b0, 7, 1'b0);
    endtask

    // R7: toggle candidate rejected, fresh reference taken afterwards.
    task automatic t_toggle_spur();
        resp[0] = 8'h00; resp[1] = 8'h00; resp[2] = 8'h00; resp[3] = 8'hFF; fill_tail(4);
        run_case("R7", 1'b1, 8'hFF, 17'h12345, 1'b0, 7, 1'b0);
    endtask

    // R8: bit 6 toggles forever.
    task automatic t_toggle_timeout();
        for (int j = 0; j < NRESP; j++) resp[j] = (j % 2 == 0) ? 8'h00 : 8'h40;
        run_case("R8", 1'b1, 8'hFF, 17'h00777, 1'b1, MAX_POLLS, 1'b0);
    endtask

    // R2: start pulse during an operation is ignored.
    task automatic t_start_busy();
        resp[0] = 8'hDA; resp[1] = 8'hDA; resp[2] = 8'hDA; resp[3] = 8'h5A; fill_tail(4);
        run_case("R2", 1'b0, 8'h5A, 17'h03C3C, 1'b0, 6, 1'b1);
    endtask

    initial begin
        for (int j = 0; j < NRESP; j++) resp[j] = 8'hFF;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check(flash_ce_n_o && flash_oe_n_o && flash_we_n_o, "R1", "strobes high in reset",
              int'({flash_ce_n_o, flash_oe_n_o, flash_we_n_o}), 7);
        check(!done_o && !busy_o && !fail_o, "R1", "status low in reset",
              int'({done_o, busy_o, fail_o}), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(rd_idx == 0 && flash_oe_n_o, "R9", "no read before start", rd_idx, 0);
        t_dpoll_fast();
        t_dpoll_busy();
        t_dpoll_spur_a();
        t_dpoll_spur_b();
        t_dpoll_timeout();
        t_toggle_basic();
        t_toggle_spur();
        t_toggle_timeout();
        t_start_busy();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "WD", "watchdog expired", 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule